// File: doc/BRIEF.md
# Sixteen-Voice Stereo Pulse Tone Generator

This block synthesises up to sixteen square/pulse tones at once and mixes them into a signed stereo sample pair. Software, or a bus bridge in front of the block, programs each voice through a byte-wide write port. Every voice owns a four-byte slot in a 64-byte register bank. The slot holds a 16-bit pitch word, a 6-bit loudness with two side-enable flags, and a 6-bit pulse width together with a 2-bit shape code.

A sample-rate strobe drives the output. On each strobe every voice first contributes to the mix from its current phase, and then its 17-bit phase accumulator advances by its pitch word. The pulse is high while the upper seven phase bits do not exceed the pulse-width value, so the high fraction is (width+1)/128. A high pulse contributes plus the loudness and a low pulse contributes minus the loudness. The contributions of all voices enabled for a side are summed into that side's output, which is wide enough for the worst case. Only shape code 0 (pulse) sounds; every other code gives a contribution of zero.

Top module: `pulse_psg`

## Requirements
- R1: While reset is asserted and after its release, both outputs read zero, `sampleValid` is low and every phase accumulator holds zero.
- R2: A write with `wrEn` high stores `wrData` in byte `wrAddr` of the bank. Byte k (0..3) of voice n sits at address 4*n+k, and a write changes no other byte.
- R3: The pitch word of a voice is {byte1, byte0}, with byte 0 as the low half. On each sample strobe the 17-bit phase becomes (phase + pitch) mod 2^17.
- R4: The pulse width is byte 3 bits 5:0. The pulse is high when phase bits 16:10 are at most the width, so a width of 63 gives exactly 64 high samples in 128.
- R5: The loudness is byte 2 bits 5:0. A voice contributes +loudness when its pulse is high and -loudness when it is low, so a loudness of 0 is silent.
- R6: Byte 2 bit 6 adds the voice to the left sum and byte 2 bit 7 adds it to the right sum. The value 0xFF gives full loudness on both sides.
- R7: The shape code is byte 3 bits 7:6. Code 0 is pulse, and codes 1, 2 and 3 contribute zero to both sides.
- R8: The outputs are signed two's-complement, 11 bits for 16 voices. The extremes +1008 and -1008 are reproduced without wrap.
- R9: The outputs and a one-cycle `sampleValid` pulse appear in the clock after a `sampleTick` edge. Without a strobe the outputs hold their value, even while registers are rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register byte write enable |
| wrAddr | input | 6 | Byte address in the voice bank |
| wrData | input | 8 | Byte to write |
| sampleTick | input | 1 | Sample-rate strobe, one cycle per sample |
| sampleValid | output | 1 | Pulses the cycle after a strobe |
| leftOut | output | 11 | Signed left mix |
| rightOut | output | 11 | Signed right mix |

## Verification
The bench sweeps every pulse width from 0 to 63 on one voice with a pitch that steps the upper phase bits by exactly one per sample. This makes the high-sample count per 128-sample period an exact, width-dependent number, which separates an off-by-one compare or a wrong phase slice from a correct one. The bench also tries all four side-enable combinations and every non-pulse shape code, and it drives all sixteen voices to both mix extremes to expose truncation. Long runs of random byte writes followed by strobes are compared against an arithmetic model, which catches a wrong address decode, a swapped pitch byte order or a faulty phase wrap. A quiet interval with register writes but no strobe confirms that the outputs hold.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int VOL_W  = 6;
  localparam int DUTY_W = 6;
  localparam int FREQ_W = 16;
  localparam int WAVE_W = 2;
  localparam int BYTES_PER_VOICE = 4;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [VOL_W-1:0]  vol;
    logic              leftEn;
    logic              rightEn;
    logic [DUTY_W-1:0] duty;
    logic [WAVE_W-1:0] wave;
  } voice_cfg_t;

  typedef struct packed {
    logic advance;
    logic capture;
  } psg_strobe_t;
endpackage

// File: rtl/psg_regbank.sv
module psg_regbank
  import psg_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int ADDR_W = $clog2(NUM_VOICES * BYTES_PER_VOICE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              sampleTick,
  output voice_cfg_t        cfg [NUM_VOICES],
  output psg_strobe_t       strobe
);
  localparam int BANK_BYTES = NUM_VOICES * BYTES_PER_VOICE;

  logic [7:0] bank [BANK_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BANK_BYTES; i++) bank[i] <= '0;
    end else if (wrEn) begin
      bank[wrAddr] <= wrData;
    end
  end

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_unpack
    assign cfg[v].freq    = {bank[v*BYTES_PER_VOICE+1], bank[v*BYTES_PER_VOICE]};
    assign cfg[v].vol     = bank[v*BYTES_PER_VOICE+2][VOL_W-1:0];
    assign cfg[v].leftEn  = bank[v*BYTES_PER_VOICE+2][6];
    assign cfg[v].rightEn = bank[v*BYTES_PER_VOICE+2][7];
    assign cfg[v].duty    = bank[v*BYTES_PER_VOICE+3][DUTY_W-1:0];
    assign cfg[v].wave    = bank[v*BYTES_PER_VOICE+3][7:6];
  end

  assign strobe.advance = sampleTick;
  assign strobe.capture = sampleTick;

  // R2
  bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> bank[$past(wrAddr)] == $past(wrData));
endmodule

// File: rtl/psg_voice_dp.sv
module psg_voice_dp
  import psg_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int PHASE_W = 17,
  parameter int MIX_W = VOL_W + $clog2(NUM_VOICES) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  voice_cfg_t               cfg [NUM_VOICES],
  input  psg_strobe_t              strobe,
  output logic                     sampleValid,
  output logic signed [MIX_W-1:0]  leftOut,
  output logic signed [MIX_W-1:0]  rightOut
);
  localparam int CMP_W = DUTY_W + 1;
  localparam int MAX_MAG = NUM_VOICES * ((1 << VOL_W) - 1);

  logic [PHASE_W-1:0]       phase   [NUM_VOICES];
  logic signed [MIX_W-1:0]  contrib [NUM_VOICES];
  logic signed [MIX_W-1:0]  sumLeft, sumRight;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    logic [CMP_W-1:0]        phaseTop;
    logic                    pulseHigh;
    logic signed [MIX_W-1:0] volExt;

    assign phaseTop  = phase[v][PHASE_W-1 -: CMP_W];
    assign pulseHigh = phaseTop <= CMP_W'(cfg[v].duty);
    assign volExt    = MIX_W'(cfg[v].vol);

    always_comb begin
      if (cfg[v].wave != '0) contrib[v] = '0;
      else if (pulseHigh)    contrib[v] = volExt;
      else                   contrib[v] = -volExt;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)              phase[v] <= '0;
      else if (strobe.advance) phase[v] <= PHASE_W'(phase[v] + PHASE_W'(cfg[v].freq));
    end

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.advance |=> $stable(phase[v]));
  end

  always_comb begin
    sumLeft  = '0;
    sumRight = '0;
    for (int v = 0; v < NUM_VOICES; v++) begin
      if (cfg[v].leftEn)  sumLeft  = sumLeft  + contrib[v];
      if (cfg[v].rightEn) sumRight = sumRight + contrib[v];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.capture;
      if (strobe.capture) begin
        leftOut  <= sumLeft;
        rightOut <= sumRight;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> sampleValid);
  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> !sampleValid);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> ($stable(leftOut) && $stable(rightOut)));
  // R8
  mix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(leftOut) <= MAX_MAG) && (int'(leftOut) >= -MAX_MAG) &&
    (int'(rightOut) <= MAX_MAG) && (int'(rightOut) >= -MAX_MAG));
endmodule

// File: rtl/pulse_psg.sv
module pulse_psg
  import psg_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int PHASE_W = 17,
  parameter int ADDR_W = $clog2(NUM_VOICES * BYTES_PER_VOICE),
  parameter int MIX_W = VOL_W + $clog2(NUM_VOICES) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [7:0]              wrData,
  input  logic                    sampleTick,
  output logic                    sampleValid,
  output logic signed [MIX_W-1:0] leftOut,
  output logic signed [MIX_W-1:0] rightOut
);
  voice_cfg_t  cfg [NUM_VOICES];
  psg_strobe_t strobe;

  psg_regbank #(.NUM_VOICES(NUM_VOICES), .ADDR_W(ADDR_W)) regbank_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleTick(sampleTick), .cfg(cfg), .strobe(strobe)
  );

  psg_voice_dp #(.NUM_VOICES(NUM_VOICES), .PHASE_W(PHASE_W), .MIX_W(MIX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .strobe(strobe),
    .sampleValid(sampleValid), .leftOut(leftOut), .rightOut(rightOut)
  );
endmodule

// File: tb/pulse_psg_tb.sv
module pulse_psg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic sampleTick = 1'b0;
  logic sampleValid;
  logic signed [10:0] leftOut, rightOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] modelBank [64];
  int modelPhase [NV];
  int expL, expR;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_psg dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleTick(sampleTick), .sampleValid(sampleValid),
    .leftOut(leftOut), .rightOut(rightOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 6'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
    modelBank[addr] = 8'(data);
  endtask

  task automatic modelSample();
    expL = 0; expR = 0;
    for (int v = 0; v < NV; v++) begin
      int freq, vol, duty, wave, top, c;
      freq = {modelBank[4*v+1], modelBank[4*v]};
      vol  = modelBank[4*v+2] & 8'h3F;
      duty = modelBank[4*v+3] & 8'h3F;
      wave = modelBank[4*v+3] >> 6;
      top  = modelPhase[v] >> 10;
      if (wave != 0) c = 0;
      else if (top <= duty) c = vol;
      else c = -vol;
      if (modelBank[4*v+2][6]) expL += c;
      if (modelBank[4*v+2][7]) expR += c;
      modelPhase[v] = (modelPhase[v] + freq) % 131072;
    end
  endtask

  // one strobe; outputs compared against the model in the cycle after
  task automatic tick(input string req);
    @(negedge clk);
    sampleTick = 1'b1;
    modelSample();
    @(negedge clk);
    sampleTick = 1'b0;
    check({req, " valid"}, int'(sampleValid), 1);
    check({req, " left"}, int'(leftOut), expL);
    check({req, " right"}, int'(rightOut), expR);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int highCount, lastL, lastR;
    for (int i = 0; i < 64; i++) modelBank[i] = 8'h00;
    for (int v = 0; v < NV; v++) modelPhase[v] = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 left in reset", int'(leftOut), 0);
    check("R1 right in reset", int'(rightOut), 0);
    check("R1 valid in reset", int'(sampleValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(sampleValid), 0);

    // R5: all loudness zero gives silence
    tick("R5 silent bank");

    // R4 R3 R2: pulse width sweep on voice 3, one top-phase step per sample
    wr(12, 8'h00); wr(13, 8'h04); wr(14, 8'hFF);
    for (int d = 0; d < 64; d++) begin
      wr(15, d);
      highCount = 0;
      for (int s = 0; s < 128; s++) begin
        tick("R4 width sweep");
        if (leftOut > 0) highCount++;
      end
      check("R4 high count per period", highCount, d + 1);
    end

    // R6: side routing, loudness 40
    for (int r = 0; r < 4; r++) begin
      wr(14, (r << 6) | 40);
      repeat (4) tick("R6 routing");
    end

    // R7: non-pulse shape codes are silent
    wr(14, 8'hFF);
    for (int w = 1; w < 4; w++) begin
      wr(15, (w << 6) | 63);
      repeat (3) tick("R7 shape silent");
      check("R7 left zero", int'(leftOut), 0);
    end

    // R8: all voices at the mix extremes
    for (int v = 0; v < NV; v++) begin
      wr(4*v, 0); wr(4*v+1, 0); wr(4*v+2, 8'hFF); wr(4*v+3, 63);
    end
    for (int v = 0; v < NV; v++) modelPhase[v] = modelPhase[v];
    tick("R8 positive extreme");
    check("R8 left max", int'(leftOut), (modelPhase[3] == 0) ? 1008 : expL);
    for (int v = 0; v < NV; v++) begin
      wr(4*v+1, 8'h80); wr(4*v+3, 0);
    end
    repeat (4) begin
      tick("R8 alternating extreme");
      if (expL < 0) check("R8 negative extreme", int'(leftOut), -1008);
    end

    // R2 R3: random programming compared with the model
    for (int k = 0; k < 300; k++) begin
      int n;
      n = 1 + ($urandom % 6);
      for (int j = 0; j < n; j++) wr($urandom % 64, $urandom % 256);
      repeat (1 + ($urandom % 4)) tick("R2 R3 random");
    end

    // R9: no strobe keeps outputs still despite writes
    tick("R9 reference");
    lastL = int'(leftOut); lastR = int'(rightOut);
    for (int j = 0; j < 8; j++) begin
      wr(j * 8 + 2, 8'hFF);
      check("R9 no valid without strobe", int'(sampleValid), 0);
    end
    check("R9 left held", int'(leftOut), lastL);
    check("R9 right held", int'(rightOut), lastR);
    tick("R9 after quiet interval");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule